// File: doc/BRIEF.md
# Prescaled Overflow Alarm Timer

This block is a 16-bit up-counting timer behind a small 32-bit register bus, meant to raise a wake-up alarm after a programmed number of slow ticks. Software picks a count source (off, the system clock, or an external fixed-frequency tick enable) and a power-of-two prescaler. It also sets a start value and a limit. The counter climbs from the start value to the limit. On the next prescaled tick it goes back to the start value and sets an overflow flag. When enabled, that flag drives a registered level interrupt.

To arm an alarm of N prescaled ticks, software writes N-1 as the limit and makes any write to the counter register. That write loads the start value. Software then selects a source. The flag stays set until software writes a 0 to its bit, so the interrupt line holds until it is acknowledged.

Top module: `ovf_alarm_timer`

## Requirements
- R1: After reset, the control register, the counter and the start register read 0, the limit reads 0x0000FFFF, and irq_out is 0.
- R2: Registers are mapped at bus addresses 0x00 (control), 0x04 (counter), 0x08 (limit) and 0x4C (start). In the control register, the prescale field is bits [2:0], the source select is bits [4:3], the interrupt enable is bit 6 and the overflow flag is bit 7. Bit 5 and bits [31:8] read 0. The counter, limit and start registers read 0 above bit 15, and only the low 16 bits of data written to the limit and start registers are kept.
- R3: Source select 1 gives one source pulse per clock cycle, and 2 gives one source pulse per cycle in which tick_in is high. Source select 0 and source select 3 stop the counter.
- R4: A prescale value p passes every 2^p-th source pulse to the counter, so p = 7 advances the counter once per 128 source pulses.
- R5: On each prescaled tick, the counter increments by one when it does not equal the limit. On a prescaled tick where it equals the limit, it loads the start value.
- R6: The overflow flag sets on the same edge where a prescaled tick moves the counter from the limit to the start value.
- R7: A bus write to the counter address loads the start value, whatever the write data. A prescaled tick in the same cycle is ignored and does not set the flag.
- R8: Writing the control register with bit 7 = 0 clears the flag, and writing it with bit 7 = 1 leaves the flag unchanged. If an overflow and a clearing write fall in the same cycle, the flag ends up set.
- R9: irq_out equals the AND of the flag and the interrupt enable as they stood one cycle earlier.
- R10: While the source select is 0 or 3, the prescaler phase is held at zero. After the counter is restarted, its first advance comes 2^p source pulses later.
- R11: Reads from any other address return 0, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Fixed-frequency tick enable, one cycle high per tick |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Registered overflow interrupt level |

## Verification
The bound checker tests these rules on every cycle:
- the reload to the start value and the flag set when the counter passes the limit;
- the counter load on a write to the counter address;
- the clear-versus-set rules of the flag;
- the one-cycle lag of the interrupt;
- the counter freezing while stopped and the prescaler phase reset while stopped.

The division ratio of each prescale setting, the gating of the count by tick_in, the read layout, and the dropping of unmapped writes are shown only by the bench scenarios. In those scenarios a behavioural model steps through each register value and is compared with the read data and the interrupt on every clock.

// File: rtl/ovf_alarm_pkg.sv
package ovf_alarm_pkg;

   localparam int unsigned BUS_W   = 32;
   localparam int unsigned PS_W    = 3;
   localparam int unsigned DIV_W   = (1 << PS_W) - 1;

   localparam int unsigned OFS_CTRL  = 'h00;
   localparam int unsigned OFS_COUNT = 'h04;
   localparam int unsigned OFS_LIMIT = 'h08;
   localparam int unsigned OFS_START = 'h4C;

   typedef enum logic [1:0] {
      SRC_OFF  = 2'd0,
      SRC_SYS  = 2'd1,
      SRC_TICK = 2'd2,
      SRC_RSVD = 2'd3
   } src_sel_e;

   typedef struct packed {
      logic            flag;
      logic            ie;
      logic            rsvd;
      src_sel_e        src;
      logic [PS_W-1:0] ps;
   } ctrl_t;

   function automatic logic src_running(src_sel_e s);
      return (s == SRC_SYS) || (s == SRC_TICK);
   endfunction

endpackage

// File: rtl/ovf_alarm_prescaler.sv
module ovf_alarm_prescaler
   import ovf_alarm_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  src_sel_e             src,
   input  logic [PS_W-1:0]      ps,
   input  logic                 tick_in,
   output logic                 pre_tick,
   output logic [DIV_W-1:0]     div_cnt
);

   logic             src_pulse;
   logic [DIV_W-1:0] div_mask;
   logic [DIV_W-1:0] div_q;

   always_comb begin
      unique case (src)
         SRC_SYS:  src_pulse = 1'b1;
         SRC_TICK: src_pulse = tick_in;
         default:  src_pulse = 1'b0;
      endcase
   end

   assign div_mask = ~({DIV_W{1'b1}} << ps);
   assign pre_tick = src_pulse && ((div_q & div_mask) == div_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (!src_running(src)) begin
         div_q <= '0;
      end else if (src_pulse) begin
         div_q <= div_q + 1'b1;
      end
   end

   assign div_cnt = div_q;

endmodule

// File: rtl/ovf_alarm_counter.sv
module ovf_alarm_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_tick,
   input  logic             load,
   input  logic [CNT_W-1:0] limit,
   input  logic [CNT_W-1:0] start,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf_evt
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_limit;

   assign at_limit = (cnt_q == limit);
   assign ovf_evt  = pre_tick && at_limit && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= start;
      end else if (pre_tick) begin
         if (at_limit) cnt_q <= start;
         else          cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/ovf_alarm_regs.sv
module ovf_alarm_regs
   import ovf_alarm_pkg::*;
#(
   parameter int unsigned    CNT_W     = 16,
   parameter int unsigned    ADDR_W    = 8,
   parameter logic [CNT_W-1:0] LIMIT_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              ovf_evt,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  limit,
   output logic [CNT_W-1:0]  start,
   output logic              cnt_load
);

   localparam int unsigned PAD_W = BUS_W - CNT_W;

   logic sel_ctrl, sel_count, sel_limit, sel_start;
   logic wr_ctrl, flag_clr;
   ctrl_t wr_view;
   ctrl_t ctrl_q;
   logic [CNT_W-1:0] limit_q, start_q;
   logic [BUS_W-1:0] cnt_ext, limit_ext, start_ext;

   assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_count = (bus_addr == ADDR_W'(OFS_COUNT));
   assign sel_limit = (bus_addr == ADDR_W'(OFS_LIMIT));
   assign sel_start = (bus_addr == ADDR_W'(OFS_START));

   assign wr_ctrl  = bus_we && sel_ctrl;
   assign wr_view  = ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
   assign flag_clr = wr_ctrl && !wr_view.flag;
   assign cnt_load = bus_we && sel_count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.ps  <= wr_view.ps;
            ctrl_q.src <= wr_view.src;
            ctrl_q.ie  <= wr_view.ie;
         end
         if (ovf_evt)       ctrl_q.flag <= 1'b1;
         else if (flag_clr) ctrl_q.flag <= 1'b0;
         ctrl_q.rsvd <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limit_q <= LIMIT_RST;
         start_q <= '0;
      end else if (bus_we) begin
         if (sel_limit) limit_q <= bus_wdata[CNT_W-1:0];
         if (sel_start) start_q <= bus_wdata[CNT_W-1:0];
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign cnt_ext   = {{PAD_W{1'b0}}, cnt};
         assign limit_ext = {{PAD_W{1'b0}}, limit_q};
         assign start_ext = {{PAD_W{1'b0}}, start_q};
      end else begin : g_nopad
         assign cnt_ext   = cnt;
         assign limit_ext = limit_q;
         assign start_ext = start_q;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl)
         bus_rdata = {{(BUS_W-$bits(ctrl_t)){1'b0}}, ctrl_q};
      else if (sel_count)
         bus_rdata = cnt_ext;
      else if (sel_limit)
         bus_rdata = limit_ext;
      else if (sel_start)
         bus_rdata = start_ext;
   end

   assign ctrl  = ctrl_q;
   assign limit = limit_q;
   assign start = start_q;

endmodule

// File: rtl/ovf_alarm_timer.sv
module ovf_alarm_timer
   import ovf_alarm_pkg::*;
#(
   parameter int unsigned      CNT_W     = 16,
   parameter int unsigned      ADDR_W    = 8,
   parameter logic [CNT_W-1:0] LIMIT_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_out
);

   generate
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
         $error("ovf_alarm_timer: CNT_W must lie in 2..32");
      end
      if ((1 << ADDR_W) <= OFS_START) begin : g_bad_addr
         $error("ovf_alarm_timer: ADDR_W too narrow for the register map");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [CNT_W-1:0] limit, start, cnt;
   logic             cnt_load, ovf_evt, pre_tick;
   logic [DIV_W-1:0] div_cnt;
   logic             irq_q;

   ovf_alarm_regs #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .LIMIT_RST(LIMIT_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt(cnt), .ovf_evt(ovf_evt),
      .ctrl(ctrl), .limit(limit), .start(start), .cnt_load(cnt_load)
   );

   ovf_alarm_prescaler u_pre (
      .clk(clk), .rst_n(rst_n),
      .src(ctrl.src), .ps(ctrl.ps), .tick_in(tick_in),
      .pre_tick(pre_tick), .div_cnt(div_cnt)
   );

   ovf_alarm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .pre_tick(pre_tick), .load(cnt_load),
      .limit(limit), .start(start),
      .cnt(cnt), .ovf_evt(ovf_evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= ctrl.flag && ctrl.ie;
   end

   assign irq_out = irq_q;

endmodule

// File: rtl/ovf_alarm_checker.sv
module ovf_alarm_checker
   import ovf_alarm_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq_out,
   input logic              flag,
   input logic              ie,
   input logic [1:0]        src,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  limit,
   input logic [CNT_W-1:0]  start,
   input logic              pre_tick,
   input logic [DIV_W-1:0]  div_cnt
);

   logic wr_count, wr_clear, wrap, stopped;
   assign wr_count = bus_we && (bus_addr == ADDR_W'(OFS_COUNT));
   assign wr_clear = bus_we && (bus_addr == ADDR_W'(OFS_CTRL)) && !bus_wdata[7];
   assign wrap     = pre_tick && (cnt == limit) && !wr_count;
   assign stopped  = (src == 2'd0) || (src == 2'd3);

   // R3: no prescaled tick and a frozen counter while stopped
   assert_stop_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !wr_count) |=> $stable(cnt));
   assert_no_tick_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |-> !pre_tick);

   // R5: limit reached on a tick -> start value
   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == $past(start)));
   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_tick && (cnt != limit) && !wr_count) |=> (cnt == $past(cnt) + 1'b1));

   // R6: flag set on wrap
   assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag);

   // R7: counter write loads start value
   assert_count_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_count |=> (cnt == $past(start)));

   // R8: clear and hold of the flag
   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clear && !wrap) |=> !flag);
   assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !wr_clear) |=> flag);
   assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(wrap));

   // R9: registered interrupt
   assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_out == $past(flag && ie)));

   // R10: prescaler phase held at zero while stopped
   assert_phase_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |=> (div_cnt == '0));

endmodule

bind ovf_alarm_timer ovf_alarm_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .irq_out(irq_out), .flag(ctrl.flag), .ie(ctrl.ie),
   .src(ctrl.src), .cnt(cnt), .limit(limit), .start(start),
   .pre_tick(pre_tick), .div_cnt(div_cnt)
);

// File: tb/ovf_alarm_timer_bench.sv
`timescale 1ns/1ps
module ovf_alarm_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_in = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // reference model state
   int m_ps = 0, m_src = 0, m_ie = 0, m_flag = 0;
   int m_lim = 'hFFFF, m_start = 0, m_cnt = 0, m_div = 0, m_irq = 0;
   int lfsr = 'hACE1;

   always #2 clk = ~clk;

   ovf_alarm_timer u_ovf_alarm_timer (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
      .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   function automatic int exp_read(int a);
      case (a)
         'h00: return m_flag * 128 + m_ie * 64 + m_src * 8 + m_ps;
         'h04: return m_cnt;
         'h08: return m_lim;
         'h4C: return m_start;
         default: return 0;
      endcase
   endfunction

   task automatic check(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step(logic we, int a, logic [31:0] d, logic tk);
      int src_p, pmask, pt, cwr, n_cnt, evt, n_div, n_flag;
      src_p = (m_src == 1) || (m_src == 2 && tk) ? 1 : 0;
      pmask = (1 << m_ps) - 1;
      pt    = (src_p != 0 && (m_div & pmask) == pmask) ? 1 : 0;
      cwr   = (we && a == 'h04) ? 1 : 0;
      n_cnt = m_cnt; evt = 0;
      if (cwr != 0) n_cnt = m_start;
      else if (pt != 0) begin
         if (m_cnt == m_lim) begin n_cnt = m_start; evt = 1; end
         else n_cnt = (m_cnt + 1) & 'hFFFF;
      end
      if (m_src == 0 || m_src == 3) n_div = 0;
      else if (src_p != 0)          n_div = (m_div + 1) % 128;
      else                          n_div = m_div;
      n_flag = m_flag;
      if (evt != 0) n_flag = 1;
      else if (we && a == 'h00 && !d[7]) n_flag = 0;
      m_irq = m_flag * m_ie;
      if (we && a == 'h00) begin
         m_ps = int'(d[2:0]); m_src = int'(d[4:3]); m_ie = int'(d[6]);
      end
      if (we && a == 'h08) m_lim = int'(d[15:0]);
      if (we && a == 'h4C) m_start = int'(d[15:0]);
      m_flag = n_flag; m_cnt = n_cnt; m_div = n_div;
   endtask

   // one bus cycle, outputs compared after the edge
   task automatic cyc(logic we, int a, logic [31:0] d, logic tk, string tag);
      bus_we = we; bus_addr = 8'(a); bus_wdata = d; tick_in = tk;
      model_step(we, a, d, tk);
      @(posedge clk);
      @(negedge clk);
      check(tag, int'(bus_rdata), exp_read(a));
      check("R9 irq", int'(irq_out), m_irq);
   endtask

   task automatic wr(int a, logic [31:0] d, string tag);
      cyc(1'b1, a, d, 1'b0, tag);
   endtask

   task automatic run(int n, int a, int tick_mode, string tag);
      for (int i = 0; i < n; i++) begin
         logic tk;
         lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 'hB400 : 0)) & 'hFFFF;
         tk = (tick_mode == 2) ? lfsr[0] : (tick_mode == 1);
         cyc(1'b0, a, 32'd0, tk, tag);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values observed while reset held
      bus_addr = 8'h00; #0.1 check("R1 ctrl", int'(bus_rdata), 0);
      bus_addr = 8'h04; #0.1 check("R1 count", int'(bus_rdata), 0);
      bus_addr = 8'h08; #0.1 check("R1 limit", int'(bus_rdata), 'hFFFF);
      bus_addr = 8'h4C; #0.1 check("R1 start", int'(bus_rdata), 0);
      check("R1 irq", int'(irq_out), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: upper bits dropped, bit 5 reads zero
      wr('h08, 32'hFFFF_1234, "R2 limit upper");
      wr('h4C, 32'hABCD_0003, "R2 start upper");
      wr('h00, 32'hFFFF_FF20, "R2 ctrl layout");
      wr('h00, 32'h0000_0000, "R2 ctrl zero");

      // R11: unmapped addresses
      wr('h10, 32'hFFFF_FFFF, "R11 unmapped write");
      wr('h4C, 32'h0000_0000, "R11 start intact");
      run(1, 'h08, 0, "R11 limit intact");
      run(1, 'h00, 0, "R11 ctrl intact");

      // R5/R6/R9: system clock, p=0, limit 4, interrupt on
      wr('h08, 32'd4, "R5 limit");
      wr('h04, 32'd0, "R7 load");
      wr('h00, 32'h0000_0048, "R3 sys src");
      run(12, 'h04, 0, "R5 count");
      run(3, 'h00, 0, "R6 flag");

      // R8: writing 1 keeps, writing 0 clears
      wr('h00, 32'h0000_00C8, "R8 write one keeps");
      wr('h00, 32'h0000_0040, "R8 write zero clears");
      run(2, 'h00, 0, "R9 irq drop");
      // R8: repeated clears while wrapping every 3 ticks, set wins
      wr('h08, 32'd2, "R8 limit");
      for (int i = 0; i < 12; i++) wr('h00, 32'h0000_0048, "R8 set wins");
      run(4, 'h00, 0, "R8 after");

      // R7: counter write loads start, data ignored
      wr('h00, 32'h0000_0000, "R7 stop");
      wr('h4C, 32'd10, "R7 start");
      wr('h08, 32'd13, "R7 limit");
      wr('h04, 32'h0000_DEAD, "R7 load ignores data");
      wr('h00, 32'h0000_0008, "R7 run");
      run(3, 'h04, 0, "R7 count");
      wr('h04, 32'h0000_0005, "R7 load while running");
      run(6, 'h04, 0, "R5 reload to start");
      run(1, 'h00, 0, "R6 flag after wrap");

      // R4: prescale 2 and 7 on system clock
      wr('h00, 32'h0000_0000, "R4 stop");
      wr('h4C, 32'd0, "R4 start");
      wr('h08, 32'd3, "R4 limit");
      wr('h04, 32'd0, "R4 load");
      wr('h00, 32'h0000_000A, "R4 p2");
      run(40, 'h04, 0, "R4 p2 count");
      wr('h00, 32'h0000_000F, "R4 p7");
      run(600, 'h04, 0, "R4 p7 count");

      // R10: phase restarts after a stop
      wr('h00, 32'h0000_000A, "R10 p2");
      run(3, 'h04, 0, "R10 partial");
      wr('h00, 32'h0000_0002, "R10 stop");
      run(2, 'h04, 0, "R10 held");
      wr('h00, 32'h0000_000A, "R10 restart");
      run(9, 'h04, 0, "R10 phase");

      // R3: tick source gated by tick_in; select 3 and 0 stop
      wr('h00, 32'h0000_0050, "R3 tick src");
      run(60, 'h04, 2, "R3 tick count");
      run(6, 'h00, 0, "R3 no ticks");
      wr('h00, 32'h0000_0058, "R3 reserved src");
      run(10, 'h04, 1, "R3 reserved stops");
      wr('h00, 32'h0000_0040, "R3 off src");
      run(10, 'h04, 1, "R3 off stops");

      // R9: enable off keeps irq low even with flag set
      wr('h00, 32'h0000_0008, "R9 ie off");
      run(20, 'h00, 0, "R9 masked");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule